// File: doc/BRIEF.md
# Paged ROM Overlay Memory Controller

This block decides which onboard memory device answers each access in a 64 KB space built from two 32 KB RAM halves and a 32 KB ROM that is seen through a 4 KB window. A byte-wide control register holds the ROM page, a ROM enable, a boot overlay flag and a user LED bit. After reset the boot overlay can make the ROM answer at every address, so the CPU fetches its first instructions from ROM at 0x0000. Once startup code clears that flag, the ROM appears only in the one 4 KB slot picked by four base switches, and RAM fills the rest of the space.

Software writes the control register through a select and a write strobe, which are sampled on the rising clock edge. It reads the control state back, together with three option switches, through a packed status byte. Chip selects are combinational from the address and the current register state. They are active high, are qualified by a memory cycle with the transaction start asserted, and are all suppressed by an external mask. A ROM write is passed on to the ROM write enable, so the ROM can be programmed in place.

Top module: `rom_overlay_ctl`

## Requirements
- R1: While reset is low, and on leaving reset, the page bits and LED read 0. The boot flag equals the `boot_strap` input and the enable flag equals the `enable_strap` input.
- R2: The control register loads `wdata` on a rising clock edge where `ctl_sel` and `ctl_wr` are both 1. The field positions are: page in bits 2..0, boot in bit 3, enable in bit 4, LED in bit 7. Bits 6..5 are discarded. Without both strobes the register holds its value.
- R3: With boot=1 and enable=1, `rom_sel` is 1 for every address of a qualified access, and neither RAM select is 1.
- R4: With enable=0, `rom_sel` is never 1, whatever the boot flag holds. `ram_lo_sel` answers when addr[15]=0 and `ram_hi_sel` answers when addr[15]=1.
- R5: With boot=0 and enable=1, `rom_sel` is 1 exactly when addr[15:12] equals `rom_base_sw`. Other addresses go to RAM as in R4.
- R6: `rom_page` equals the page bits. A page write is visible on the cycle after its clock edge. Writing a new enable value together with the same page leaves the page unchanged.
- R7: `status` is {page[2:0], enable, boot, opt_sw[2:0]}, MSB first. An `opt_sw` bit of 1 means the switch is closed.
- R8: While `ext_mask` is 1, all three selects are 0.
- R9: No select is 1 unless `mem_cycle`=1 and `xact_start`=1.
- R10: `rom_wr_en` is 1 only when `rom_sel`=1 and `rd_nwr`=0. `user_led` follows control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_strap | input | 1 | Reset value of the boot flag |
| enable_strap | input | 1 | Reset value of the ROM enable |
| rom_base_sw | input | 4 | Address bits 15..12 of the ROM slot |
| opt_sw | input | 3 | Option switches, 1 = closed |
| addr | input | 16 | CPU address |
| mem_cycle | input | 1 | 1 = memory access, 0 = I/O access |
| xact_start | input | 1 | Transaction start qualifier |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| ctl_sel | input | 1 | Control register select |
| ctl_wr | input | 1 | Control register write strobe |
| wdata | input | 8 | Data bus |
| ext_mask | input | 1 | External device overrides onboard memory |
| ram_lo_sel | output | 1 | Lower RAM half select |
| ram_hi_sel | output | 1 | Upper RAM half select |
| rom_sel | output | 1 | ROM select |
| rom_page | output | 3 | ROM address bits 14..12 |
| rom_wr_en | output | 1 | ROM write enable |
| status | output | 8 | Readable status byte |
| user_led | output | 1 | User LED drive |

## Verification
A control register write and a memory access can fall in the same cycle. The decode in that cycle must still use the old page and flags, and the new values must take effect on the next access. The bench provokes this by holding a ROM-slot access steady while it rewrites the page. It checks that `rom_page` holds the old page before the edge and shows the new page just after it. A second overlap puts the mask or an I/O cycle on top of an access that the boot overlay would otherwise send to ROM, and the bench checks that every select stays low.

// File: rtl/rom_overlay_pkg.sv
package rom_overlay_pkg;
   localparam int CTL_W      = 8;
   localparam int PG_W       = 3;
   localparam int BIT_BOOT   = 3;
   localparam int BIT_ENABLE = 4;
   localparam int BIT_LED    = 7;

   typedef struct packed {
      logic [PG_W-1:0] page;
      logic            boot;
      logic            enable;
      logic            led;
   } ctl_state_t;

   typedef struct packed {
      logic lo;
      logic hi;
      logic rom;
   } mem_sel_t;
endpackage

// File: rtl/rom_ctl_reg.sv
module rom_ctl_reg
   import rom_overlay_pkg::*;
#(
   parameter int DATA_W = CTL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_strap,
   input  logic              enable_strap,
   input  logic              wr_go,
   input  logic [DATA_W-1:0] wdata,
   output ctl_state_t        state
);
   initial begin
      if (DATA_W <= BIT_LED) $error("DATA_W too small for LED bit");
      if (PG_W > BIT_BOOT)   $error("page field overlaps boot bit");
   end

   ctl_state_t nxt;

   always_comb begin
      nxt = state;
      if (wr_go) begin
         nxt.page   = wdata[PG_W-1:0];
         nxt.boot   = wdata[BIT_BOOT];
         nxt.enable = wdata[BIT_ENABLE];
         nxt.led    = wdata[BIT_LED];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state.page   <= '0;
         state.boot   <= boot_strap;
         state.enable <= enable_strap;
         state.led    <= 1'b0;
      end else begin
         state <= nxt;
      end
   end

   // R2: without a write the register holds
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_go |=> $stable(state));
   // R6: page follows the written value one edge later
   p_page_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |=> state.page == $past(wdata[PG_W-1:0]));
endmodule

// File: rtl/rom_map_decode.sv
module rom_map_decode
   import rom_overlay_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SLOT_W = 12
) (
   input  logic                     rst_n,
   input  logic                     clk,
   input  ctl_state_t               state,
   input  logic [ADDR_W-SLOT_W-1:0] base_sw,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     qualified,
   input  logic                     ext_mask,
   output mem_sel_t                 sel
);
   localparam int BASE_W = ADDR_W - SLOT_W;

   initial begin
      if (SLOT_W >= ADDR_W) $error("slot wider than address space");
      if (BASE_W < 1)       $error("no base bits");
   end

   logic in_slot;
   logic rom_hit;
   logic go;

   assign in_slot = (addr[ADDR_W-1 -: BASE_W] == base_sw);
   assign go      = qualified & ~ext_mask;

   always_comb begin
      rom_hit = 1'b0;
      if (state.enable)
         rom_hit = state.boot | in_slot;
   end

   always_comb begin
      sel = '0;
      if (go) begin
         if (rom_hit)                sel.rom = 1'b1;
         else if (addr[ADDR_W-1])    sel.hi  = 1'b1;
         else                        sel.lo  = 1'b1;
      end
   end

   // R3/R4/R5: one device at most
   p_one_dev_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel.lo, sel.hi, sel.rom}));
   // R4: disabled ROM never answers
   p_rom_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !state.enable |-> !sel.rom);
   // R3: overlay never lets RAM answer
   p_overlay_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state.boot && state.enable) |-> !(sel.lo || sel.hi));
   // R8: mask silences all
   p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mask |-> !(sel.lo || sel.hi || sel.rom));
endmodule

// File: rtl/rom_status_pack.sv
module rom_status_pack
   import rom_overlay_pkg::*;
#(
   parameter int OPT_W  = 3,
   parameter int DATA_W = CTL_W
) (
   input  ctl_state_t        state,
   input  logic [OPT_W-1:0]  opt_sw,
   output logic [DATA_W-1:0] status
);
   localparam int PG_LO = OPT_W + 2;

   initial begin
      if (PG_LO + PG_W != DATA_W) $error("status fields do not fill the byte");
   end

   genvar gi;
   generate
      for (gi = 0; gi < OPT_W; gi++) begin : g_opt
         assign status[gi] = opt_sw[gi];
      end
      for (gi = 0; gi < PG_W; gi++) begin : g_pg
         assign status[PG_LO+gi] = state.page[gi];
      end
   endgenerate

   assign status[OPT_W]   = state.boot;
   assign status[OPT_W+1] = state.enable;
endmodule

// File: rtl/rom_overlay_ctl.sv
module rom_overlay_ctl
   import rom_overlay_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SLOT_W = 12,
   parameter int OPT_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     boot_strap,
   input  logic                     enable_strap,
   input  logic [ADDR_W-SLOT_W-1:0] rom_base_sw,
   input  logic [OPT_W-1:0]         opt_sw,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     mem_cycle,
   input  logic                     xact_start,
   input  logic                     rd_nwr,
   input  logic                     ctl_sel,
   input  logic                     ctl_wr,
   input  logic [CTL_W-1:0]         wdata,
   input  logic                     ext_mask,
   output logic                     ram_lo_sel,
   output logic                     ram_hi_sel,
   output logic                     rom_sel,
   output logic [PG_W-1:0]          rom_page,
   output logic                     rom_wr_en,
   output logic [CTL_W-1:0]         status,
   output logic                     user_led
);
   ctl_state_t st;
   mem_sel_t   sel;
   logic       qualified;

   assign qualified = mem_cycle & xact_start;

   rom_ctl_reg #(.DATA_W(CTL_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap),
      .enable_strap(enable_strap), .wr_go(ctl_sel & ctl_wr),
      .wdata(wdata), .state(st));

   rom_map_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_dec (
      .rst_n(rst_n), .clk(clk), .state(st), .base_sw(rom_base_sw),
      .addr(addr), .qualified(qualified), .ext_mask(ext_mask), .sel(sel));

   rom_status_pack #(.OPT_W(OPT_W), .DATA_W(CTL_W)) u_stat (
      .state(st), .opt_sw(opt_sw), .status(status));

   assign ram_lo_sel = sel.lo;
   assign ram_hi_sel = sel.hi;
   assign rom_sel    = sel.rom;
   assign rom_page   = st.page;
   assign rom_wr_en  = sel.rom & ~rd_nwr;
   assign user_led   = st.led;

   // R9: unqualified cycles select nothing
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_cycle && xact_start) |-> !(ram_lo_sel || ram_hi_sel || rom_sel));
   // R10: ROM write only on a write access to ROM
   p_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rom_wr_en |-> (rom_sel && !rd_nwr));
   // R7: status page field mirrors the ROM page lines
   p_stat_pg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status[CTL_W-1 -: PG_W] == rom_page);
endmodule

// File: tb/test_rom_overlay_ctl.sv
`timescale 1ns/1ps
module test_rom_overlay_ctl;
   logic clk = 0;
   always #2 clk = ~clk;

   logic rst_n, boot_strap, enable_strap;
   logic [3:0] rom_base_sw;
   logic [2:0] opt_sw;
   logic [15:0] addr;
   logic mem_cycle, xact_start, rd_nwr, ctl_sel, ctl_wr, ext_mask;
   logic [7:0] wdata;
   logic ram_lo_sel, ram_hi_sel, rom_sel, rom_wr_en, user_led;
   logic [2:0] rom_page;
   logic [7:0] status;

   int checks = 0, errors = 0;

   rom_overlay_ctl i_rom_overlay_ctl (.*);

   // {ctl, addr, mem, start, rd, mask, lo, hi, rom, wr}
   localparam logic [31:0] TBL [12] = '{
      32'h18_0000_E_2, 32'h18_8123_C_3, 32'h13_F456_E_2, 32'h13_7000_E_8,
      32'h13_E000_C_4, 32'h08_0000_E_8, 32'h05_FFFF_E_4, 32'h18_1234_F_0,
      32'h18_1234_6_0, 32'h13_F000_A_0, 32'h77_F800_E_2, 32'h14_0FFF_E_8};

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [7:0] d);
      @(negedge clk);
      ctl_sel = 1; ctl_wr = 1; wdata = d;
      @(negedge clk);
      ctl_sel = 0; ctl_wr = 0;
   endtask

   task automatic access(input logic [15:0] a, input logic m, s, r, k);
      addr = a; mem_cycle = m; xact_start = s; rd_nwr = r; ext_mask = k;
      #1;
   endtask

   function automatic logic [3:0] sels();
      return {ram_lo_sel, ram_hi_sel, rom_sel, rom_wr_en};
   endfunction

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      rst_n = 0; boot_strap = 1; enable_strap = 1; rom_base_sw = 4'hF; opt_sw = 3'b101;
      addr = 0; mem_cycle = 0; xact_start = 0; rd_nwr = 1; ctl_sel = 0; ctl_wr = 0;
      wdata = 0; ext_mask = 0;
      repeat (3) @(negedge clk);
      // R1: reset state with both straps high
      chk("R1 status", {8'h0, status}, 16'h001D);
      chk("R1 led", {15'h0, user_led}, 16'h0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 after release", {8'h0, status}, 16'h001D);
      access(16'h0000, 1, 1, 1, 0);
      chk("R3 boot fetch at 0", {12'h0, sels()}, 16'h0002);

      // table walk
      for (int i = 0; i < 12; i++) begin
         wr_ctl(TBL[i][31:24]);
         access(TBL[i][23:8], TBL[i][7], TBL[i][6], TBL[i][5], TBL[i][4]);
         chk($sformatf("R3-R5/R8-R10 vec%0d", i), {12'h0, sels()}, {12'h0, TBL[i][3:0]});
         if (rom_sel) chk("R6 page on rom lines", {13'h0, rom_page}, {13'h0, TBL[i][26:24]});
      end

      // R2/R7/R10: LED plus field layout, bits 5,6 dropped
      wr_ctl(8'hB3);
      chk("R7 status layout", {8'h0, status}, 16'h0075);
      chk("R10 led on", {15'h0, user_led}, 16'h1);
      wr_ctl(8'h60);
      chk("R2 bits 6..5 ignored", {8'h0, status}, 16'h0005);
      chk("R10 led off", {15'h0, user_led}, 16'h0);

      // R6: enable toggles keep the page
      wr_ctl(8'h16);
      wr_ctl(8'h06);
      chk("R6 page kept after enable clear", {8'h0, status}, 16'h00C5);

      // R2: select without write strobe has no effect
      @(negedge clk); ctl_sel = 1; wdata = 8'hFF;
      @(negedge clk); ctl_sel = 0;
      chk("R2 no strobe hold", {8'h0, status}, 16'h00C5);

      // same-cycle write and access: old page before edge, new after
      wr_ctl(8'h11);
      access(16'hF010, 1, 1, 1, 0);
      @(negedge clk); ctl_sel = 1; ctl_wr = 1; wdata = 8'h16; #1;
      chk("R6 old page before edge", {13'h0, rom_page}, 16'h1);
      @(posedge clk); #1;
      chk("R6 new page next access", {13'h0, rom_page}, 16'h6);
      chk("R5 still rom", {15'h0, rom_sel}, 16'h1);
      @(negedge clk); ctl_sel = 0; ctl_wr = 0;

      // R5: moved base
      rom_base_sw = 4'h2;
      wr_ctl(8'h10);
      access(16'h2ABC, 1, 1, 1, 0);
      chk("R5 base 2 hit", {12'h0, sels()}, 16'h0002);
      access(16'hF000, 1, 1, 1, 0);
      chk("R5 old slot is RAM", {12'h0, sels()}, 16'h0004);

      // R1/R4: reset with boot strap but no enable
      @(negedge clk); rst_n = 0; boot_strap = 1; enable_strap = 0; #1;
      chk("R1 strap boot only", {8'h0, status}, 16'h000D);
      @(negedge clk); rst_n = 1;
      access(16'h0000, 1, 1, 1, 0);
      chk("R4 boot without enable -> RAM", {12'h0, sels()}, 16'h0008);
      @(negedge clk); rst_n = 0; boot_strap = 0; enable_strap = 0; #1;
      chk("R1 straps low", {8'h0, status}, 16'h0005);
      @(negedge clk); rst_n = 1;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule